// File: doc/BRIEF.md
# Hall-Position Commutation Pattern Updater

This block loads motor-phase output patterns in step with three position sensors. A set of 16-bit pattern buffers is held in storage and written one byte half at a time. Software programs the next expected sensor state and a bank flag. Together these two values pick which buffer is next in line. Each sensor input is synchronized and watched for a qualifying edge. When such an edge occurs, the synchronized three-bit sensor state is compared bit for bit with the expected state. If they match, the chosen buffer is copied into the live output register and a one-cycle strobe is raised. If they differ, the output holds and a mismatch flag is set.

A firmware loop writes the next expected position and bank after each strobe. The output therefore advances one commutation step per sensor transition with no timing-critical software. The position comparison is enabled only by one operation-select code. Any other code leaves the output frozen.

Top module: `hall_pattern_updater`

## Requirements
- R1: An active-high synchronous reset `rst` clears `pat_out`, `match_stb`, `mismatch`, the expected position, the bank flag and the mode field to zero. It sets the edge-select field of every sensor to 2'b11 (both edges).
- R2: A write with `wr_addr[5]`=0 stores `wr_data` into one byte half of a buffer. `wr_addr[4:1]` is the buffer index, and `wr_addr[0]`=1 selects bits [15:8] while `wr_addr[0]`=0 selects bits [7:0]. A write with `wr_addr[5]`=1 uses `wr_addr[1:0]` to pick a control field: 00 is the expected position (`wr_data[2:0]`), 01 is the bank flag (`wr_data[0]`), 10 is the mode (`wr_data[2:0]`) and 11 is the edge select (`wr_data[5:0]`).
- R3: On a match, the buffer loaded is the one at index {bank flag, expected[2:0]}.
- R4: In mode 3'b010, a qualifying edge triggers a comparison of synchronized sensor i with expected bit i, for i = 0 to 2. A sensor change first sampled at rising edge N reaches `pat_out` at edge N+2 when all three bits match.
- R5: When the triggered comparison fails, `pat_out` keeps its value and `mismatch` is set, with the same latency as a load.
- R6: Any register write clears `mismatch`. If a mismatch is detected in the same cycle as a write, the flag is set.
- R7: Edge-select bits [2i+1:2i] belong to sensor i. Bit 2i enables rising edges and bit 2i+1 enables falling edges. With 2'b00, a change on that sensor alone triggers nothing.
- R8: With any mode other than 3'b010, sensor edges cause no load and no strobe, and they leave `mismatch` unchanged.
- R9: `match_stb` is high for exactly one cycle, in the cycle in which `pat_out` first shows the newly loaded pattern.
- R10: Without a qualifying edge no comparison takes place. Writing an expected position equal to the present sensor state reloads nothing.
- R11: Stepping the sensors through 110, 100, 101, 001, 011, 010, with the expected position set to each next state, loads a different buffer at every step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sens_in | input | 3 | Asynchronous position sensor levels |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 6 | Register write address |
| wr_data | input | 8 | Register write data |
| pat_out | output | 16 | Live phase output pattern |
| match_stb | output | 1 | One-cycle pulse on a pattern load |
| mismatch | output | 1 | Sticky flag for a failed position comparison |

## Verification
The bench builds the block with its defaults: three sensors, two banks and 16-bit patterns. This gives 16 buffers, so every index {bank, position} can be filled with a distinct value and checked. The small sensor state space lets random steps hit matching, mismatching and no-edge transitions often. The small edge-select field makes rising-only, falling-only and disabled sensors all occur within a few hundred steps. A directed sequence walks the commutation order. Another places a register write in the exact cycle a mismatch is detected.

// File: rtl/hpu_pkg.sv
package hpu_pkg;

  // control field selector, wr_addr[1:0] when the address MSB is set
  typedef enum logic [1:0] {
    CTL_EXPECT = 2'b00,
    CTL_BANK   = 2'b01,
    CTL_MODE   = 2'b10,
    CTL_EDGE   = 2'b11
  } ctl_reg_e;

  localparam logic [2:0] MODE_POSITION = 3'b010;
  localparam logic [1:0] EDGE_SEL_RESET = 2'b11;

  // sel[0] enables rising, sel[1] enables falling
  function automatic logic edge_hit(input logic [1:0] sel, input logic prev, input logic cur);
    return (sel[0] && !prev && cur) || (sel[1] && prev && !cur);
  endfunction

  // buffer index formed from bank flag and expected position
  function automatic logic [7:0] buf_index(input logic [3:0] bank, input logic [3:0] pos,
                                           input int pos_w);
    return 8'((bank << pos_w) | pos);
  endfunction

endpackage

// File: rtl/hpu_sense_sync.sv
module hpu_sense_sync #(
  parameter int NUM_SENSE = 3,
  localparam int ESEL_W = 2 * NUM_SENSE
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_SENSE-1:0] sens_in,
  input  logic [ESEL_W-1:0]    esel,
  output logic [NUM_SENSE-1:0] sens_cur,
  output logic [NUM_SENSE-1:0] sens_prev,
  output logic                 edge_evt
);
  import hpu_pkg::*;

  logic [NUM_SENSE-1:0] meta_q;
  logic [NUM_SENSE-1:0] hit;

  for (genvar i = 0; i < NUM_SENSE; i++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst) begin
        meta_q[i]    <= 1'b0;
        sens_cur[i]  <= 1'b0;
        sens_prev[i] <= 1'b0;
      end else begin
        meta_q[i]    <= sens_in[i];
        sens_cur[i]  <= meta_q[i];
        sens_prev[i] <= sens_cur[i];
      end
    end
    assign hit[i] = edge_hit(esel[2*i +: 2], sens_prev[i], sens_cur[i]);
  end

  assign edge_evt = |hit;

endmodule

// File: rtl/hpu_ctrl_regs.sv
module hpu_ctrl_regs #(
  parameter int NUM_SENSE = 3,
  parameter int BANK_W    = 1,
  localparam int ESEL_W = 2 * NUM_SENSE
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [1:0]           wr_sel,
  input  logic [ESEL_W-1:0]    wr_data,
  output logic [NUM_SENSE-1:0] exp_q,
  output logic [BANK_W-1:0]    bank_q,
  output logic [2:0]           mode_q,
  output logic [ESEL_W-1:0]    esel_q
);
  import hpu_pkg::*;

  always_ff @(posedge clk) begin
    if (rst) begin
      exp_q  <= '0;
      bank_q <= '0;
      mode_q <= '0;
      esel_q <= {NUM_SENSE{EDGE_SEL_RESET}};
    end else if (wr_en) begin
      case (ctl_reg_e'(wr_sel))
        CTL_EXPECT: exp_q  <= wr_data[NUM_SENSE-1:0];
        CTL_BANK:   bank_q <= wr_data[BANK_W-1:0];
        CTL_MODE:   mode_q <= wr_data[2:0];
        default:    esel_q <= wr_data;
      endcase
    end
  end

endmodule

// File: rtl/hpu_pattern_bank.sv
module hpu_pattern_bank #(
  parameter int PAT_W = 16,
  parameter int IDX_W = 4,
  localparam int HALF_W  = PAT_W / 2,
  localparam int NUM_BUF = 1 << IDX_W
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic              wr_upper,
  input  logic [HALF_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [PAT_W-1:0]  rd_pattern
);

  logic [PAT_W-1:0] mem [NUM_BUF];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      if (wr_upper) mem[wr_idx][PAT_W-1:HALF_W] <= wr_data;
      else          mem[wr_idx][HALF_W-1:0]     <= wr_data;
    end
  end

  assign rd_pattern = mem[rd_idx];

endmodule

// File: rtl/hall_pattern_updater.sv
module hall_pattern_updater #(
  parameter int PAT_W     = 16,
  parameter int NUM_SENSE = 3,
  parameter int BANKS     = 2,
  localparam int BANK_W = (BANKS > 1) ? $clog2(BANKS) : 1,
  localparam int IDX_W  = BANK_W + NUM_SENSE,
  localparam int HALF_W = PAT_W / 2,
  localparam int AW     = IDX_W + 2,
  localparam int ESEL_W = 2 * NUM_SENSE
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_SENSE-1:0] sens_in,
  input  logic                 wr_en,
  input  logic [AW-1:0]        wr_addr,
  input  logic [HALF_W-1:0]    wr_data,
  output logic [PAT_W-1:0]     pat_out,
  output logic                 match_stb,
  output logic                 mismatch
);
  import hpu_pkg::*;

  // named internal events, observed by the bound checker
  logic [NUM_SENSE-1:0] sens_cur;
  logic [NUM_SENSE-1:0] sens_prev;
  logic                 edge_evt;
  logic [NUM_SENSE-1:0] exp_q;
  logic [BANK_W-1:0]    bank_q;
  logic [2:0]           mode_q;
  logic [ESEL_W-1:0]    esel_q;
  logic [PAT_W-1:0]     sel_pattern;
  logic [IDX_W-1:0]     sel_idx;
  logic                 buf_we;
  logic                 ctl_we;
  logic                 mode_on;
  logic                 pos_match;
  logic                 load_en;
  logic                 mism_evt;

  assign buf_we = wr_en && !wr_addr[AW-1];
  assign ctl_we = wr_en &&  wr_addr[AW-1];

  hpu_sense_sync #(.NUM_SENSE(NUM_SENSE)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .sens_in  (sens_in),
    .esel     (esel_q),
    .sens_cur (sens_cur),
    .sens_prev(sens_prev),
    .edge_evt (edge_evt)
  );

  hpu_ctrl_regs #(.NUM_SENSE(NUM_SENSE), .BANK_W(BANK_W)) u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (ctl_we),
    .wr_sel (wr_addr[1:0]),
    .wr_data(wr_data[ESEL_W-1:0]),
    .exp_q  (exp_q),
    .bank_q (bank_q),
    .mode_q (mode_q),
    .esel_q (esel_q)
  );

  assign sel_idx = IDX_W'(buf_index(4'(bank_q), 4'(exp_q), NUM_SENSE));

  hpu_pattern_bank #(.PAT_W(PAT_W), .IDX_W(IDX_W)) u_bank (
    .clk       (clk),
    .wr_en     (buf_we),
    .wr_idx    (wr_addr[IDX_W:1]),
    .wr_upper  (wr_addr[0]),
    .wr_data   (wr_data),
    .rd_idx    (sel_idx),
    .rd_pattern(sel_pattern)
  );

  assign mode_on   = (mode_q == MODE_POSITION);
  assign pos_match = (sens_cur == exp_q);
  assign load_en   = mode_on && edge_evt && pos_match;
  assign mism_evt  = mode_on && edge_evt && !pos_match;

  always_ff @(posedge clk) begin
    if (rst) begin
      pat_out   <= '0;
      match_stb <= 1'b0;
      mismatch  <= 1'b0;
    end else begin
      match_stb <= load_en;
      if (load_en) pat_out <= sel_pattern;
      if (mism_evt)   mismatch <= 1'b1;
      else if (wr_en) mismatch <= 1'b0;
    end
  end

endmodule

// File: rtl/hall_pattern_chk.sv
module hall_pattern_chk #(
  parameter int PAT_W     = 16,
  parameter int NUM_SENSE = 3
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 wr_en,
  input logic [2:0]           mode_q,
  input logic [NUM_SENSE-1:0] sens_cur,
  input logic [NUM_SENSE-1:0] sens_prev,
  input logic                 edge_evt,
  input logic                 load_en,
  input logic                 mism_evt,
  input logic [PAT_W-1:0]     sel_pattern,
  input logic [PAT_W-1:0]     pat_out,
  input logic                 match_stb,
  input logic                 mismatch
);

  // R3
  load_chk: assert property (@(posedge clk) disable iff (rst)
    load_en |=> (match_stb && pat_out == $past(sel_pattern)));

  // R4
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !load_en |=> ($stable(pat_out) && !match_stb));

  // R5
  mism_set_chk: assert property (@(posedge clk) disable iff (rst)
    mism_evt |=> (mismatch && !match_stb));

  // R6
  mism_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !mism_evt) |=> !mismatch);

  // R7
  edge_change_chk: assert property (@(posedge clk) disable iff (rst)
    edge_evt |-> (sens_cur != sens_prev));

  // R8
  mode_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_q != 3'b010 && !wr_en) |=> ($stable(mismatch) && !match_stb));

  // R10
  no_edge_chk: assert property (@(posedge clk) disable iff (rst)
    !edge_evt |=> !match_stb);

endmodule

bind hall_pattern_updater hall_pattern_chk #(.PAT_W(PAT_W), .NUM_SENSE(NUM_SENSE)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .wr_en      (wr_en),
  .mode_q     (mode_q),
  .sens_cur   (sens_cur),
  .sens_prev  (sens_prev),
  .edge_evt   (edge_evt),
  .load_en    (load_en),
  .mism_evt   (mism_evt),
  .sel_pattern(sel_pattern),
  .pat_out    (pat_out),
  .match_stb  (match_stb),
  .mismatch   (mismatch)
);

// File: tb/tb_hall_pattern_updater.sv
`timescale 1ns/1ps
module tb_hall_pattern_updater;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  sens_in = 3'b000;
  logic        wr_en = 1'b0;
  logic [5:0]  wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [15:0] pat_out;
  logic        match_stb;
  logic        mismatch;

  int checks = 0;
  int failures = 0;

  // bench model state
  logic [15:0] m_buf [16];
  logic [2:0]  m_exp, m_mode, m_sens;
  logic        m_bank, m_mism;
  logic [5:0]  m_esel;
  logic [15:0] m_pat;

  always #10 clk = ~clk;

  hall_pattern_updater dut (
    .clk(clk), .rst(rst), .sens_in(sens_in), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data),
    .pat_out(pat_out), .match_stb(match_stb), .mismatch(mismatch)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic model_edge(input logic [2:0] oldv, input logic [2:0] newv,
                                      input logic [5:0] sel);
    logic e = 1'b0;
    for (int i = 0; i < 3; i++) begin
      if (sel[2*i]   && !oldv[i] &&  newv[i]) e = 1'b1;
      if (sel[2*i+1] &&  oldv[i] && !newv[i]) e = 1'b1;
    end
    return e;
  endfunction

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (!a[5]) begin
      if (a[0]) m_buf[a[4:1]][15:8] = d;
      else      m_buf[a[4:1]][7:0]  = d;
    end else begin
      case (a[1:0])
        2'b00: m_exp  = d[2:0];
        2'b01: m_bank = d[0];
        2'b10: m_mode = d[2:0];
        default: m_esel = d[5:0];
      endcase
    end
    m_mism = 1'b0;
    check("R6 write clears mismatch", 16'(mismatch), 16'(m_mism));
  endtask

  task automatic wr_buf(input logic [3:0] idx, input logic [15:0] v);
    wr({1'b0, idx, 1'b1}, v[15:8]);
    wr({1'b0, idx, 1'b0}, v[7:0]);
  endtask

  task automatic step(input logic [2:0] nv, input string tag);
    logic e, hit;
    e   = model_edge(m_sens, nv, m_esel);
    hit = (m_mode == 3'b010) && e && (nv == m_exp);
    if (hit) m_pat = m_buf[{m_bank, m_exp}];
    if ((m_mode == 3'b010) && e && !hit) m_mism = 1'b1;
    m_sens = nv;
    @(negedge clk);
    sens_in = nv;
    repeat (2) @(posedge clk);
    #1 check({tag, " R9 no early strobe"}, 16'(match_stb), 16'd0);
    @(posedge clk);
    #1;
    check({tag, " pat_out"}, pat_out, m_pat);
    check({tag, " R9 strobe"}, 16'(match_stb), 16'(hit));
    check({tag, " R5 mismatch"}, 16'(mismatch), 16'(m_mism));
    @(posedge clk);
    #1 check({tag, " R9 strobe one cycle"}, 16'(match_stb), 16'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [15:0] prev_pat;
    void'($urandom(32'd20240611));
    m_exp = '0; m_mode = '0; m_sens = '0; m_bank = 1'b0; m_mism = 1'b0;
    m_esel = 6'b111111; m_pat = '0;
    repeat (5) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    #1;
    // R1 reset state
    check("R1 pat_out reset", pat_out, 16'h0);
    check("R1 strobe reset", 16'(match_stb), 16'd0);
    check("R1 mismatch reset", 16'(mismatch), 16'd0);

    // R2 distinct buffer contents through half writes
    for (int i = 0; i < 16; i++) wr_buf(4'(i), 16'(16'hA000 + i * 16'h0111));

    // R1 expected and bank reset to 0, edge select resets to both edges
    wr(6'h22, 8'h02);
    step(3'b001, "R1 R5 mismatch on 001");
    step(3'b000, "R1 R3 load index 0");
    check("R1 R3 buffer 0 loaded", pat_out, 16'hA000);

    // R11 commutation walk, bank 1
    wr(6'h21, 8'h01);
    begin
      logic [2:0] seq [6] = '{3'b110, 3'b100, 3'b101, 3'b001, 3'b011, 3'b010};
      for (int k = 0; k < 6; k++) begin
        prev_pat = pat_out;
        wr(6'h20, {5'b0, seq[k]});
        step(seq[k], "R11 R4 commutation");
        check("R11 R3 index {bank,pos}", pat_out, 16'(16'hA000 + (8 + seq[k]) * 16'h0111));
        checks++;
        if (pat_out == prev_pat) begin
          failures++;
          $display("FAIL R11 pattern unchanged actual=%h expected!=%h", pat_out, prev_pat);
        end
      end
    end

    // R10 expected equal to present state, no edge: no reload
    wr(6'h20, 8'h02);
    repeat (4) @(posedge clk);
    #1 check("R10 no reload without edge", 16'(match_stb), 16'd0);

    // R7 sensor 0 ignored with select 00
    wr(6'h23, 8'b111100);
    wr(6'h20, 8'h03);
    step(3'b011, "R7 ignored sensor");
    check("R7 pat_out unchanged", pat_out, 16'(16'hA000 + 10 * 16'h0111));
    // R7 rising-only on sensor 2
    wr(6'h23, 8'b010101);
    wr(6'h20, 8'h01);
    step(3'b111, "R7 rising s2");
    step(3'b011, "R7 falling s2 ignored");
    step(3'b001, "R7 falling s1 ignored");

    // R8 mode off
    wr(6'h23, 8'h3F);
    wr(6'h22, 8'h05);
    wr(6'h20, 8'h05);
    step(3'b101, "R8 mode off");
    step(3'b100, "R8 mode off mismatch");

    // R6 write in detection cycle: set wins
    wr(6'h22, 8'h02);
    wr(6'h20, 8'h07);
    @(negedge clk) sens_in = 3'b110;
    m_sens = 3'b110;
    repeat (2) @(posedge clk);
    @(negedge clk) begin wr_en = 1'b1; wr_addr = 6'h21; wr_data = {7'b0, m_bank}; end
    @(posedge clk);
    #1 check("R6 set wins over write", 16'(mismatch), 16'd1);
    @(negedge clk) wr_en = 1'b0;
    m_mism = 1'b1;
    wr(6'h20, 8'h07);

    // random mix
    for (int n = 0; n < 400; n++) begin
      int r = $urandom_range(0, 15);
      if (r < 2)       wr(6'h20, 8'($urandom_range(0, 7)));
      else if (r == 2) wr(6'h21, 8'($urandom_range(0, 1)));
      else if (r == 3) wr(6'h22, ($urandom_range(0, 3) != 0) ? 8'h02 : 8'($urandom_range(0, 7)));
      else if (r == 4) wr(6'h23, 8'($urandom_range(0, 63)));
      else if (r == 5) wr({1'b0, 4'($urandom_range(0, 15)), 1'($urandom_range(0, 1))},
                          8'($urandom_range(0, 255)));
      else             step(3'($urandom_range(0, 7)), "R4 R3 random");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule